// File: doc/BRIEF.md
# TDM Audio Receive Serializer with Sample Formatting

This block takes a serial audio link made of a bit clock, a frame sync and one data line. For each enabled time slot it produces one formatted 32-bit parallel word. The three serial inputs are sampled in the system clock domain. Each first passes through a two-stage synchronizer, and the bit-clock edges are then found by comparing the current level with the previous one. A frame starts at a rising edge of the frame sync. Slots then follow one after another, `SLOT_W` bits each, until the configured last slot has been received.

A static set of configuration inputs controls how the raw slot bits become a word:
- the sample width;
- which end of the slot holds the sample;
- the order of the bits on the wire;
- which end of the output word receives the sample, and what the spare bits are filled with.

Two narrow widths can pack a left/right pair into one word. Any slot can be muted. Mono operation repeats the left sample on the right channel. A capture mode takes one bit on every bit-clock edge, rising and falling. A loop-back select replaces the data line with the local transmit line.

Top module: `rxfmt_top`

## Requirements
- R1: After reset `valid_o` is 0 and `data_o` is 0, and no word is produced until a frame sync rising edge has been seen.
- R2: A frame starts at the bit captured on the bit-clock rising edge where `fsync_i` is 1 after being 0 at the previous rising edge. That bit is bit 0 of slot 0. Slots of `SLOT_W` bits are numbered 0 to `last_slot_i`. Bits after the last slot are ignored until the next frame sync.
- R3: `size_i` sets the sample width: 0=32, 1=24, 2=20, 3=18, 4=16, 5=16 packed pair, 6=8, 7=8 packed pair.
- R4: With `slot_left_i`=1 the sample is the first W bits received in the slot. With 0 it is the last W bits.
- R5: With `lsb_first_i`=0 the first sample bit on the wire is the sample MSB. With 1 it is the LSB.
- R6: With `word_left_i`=0 the sample occupies `data_o[W-1:0]`. With 1 it occupies `data_o[31:32-W]`.
- R7: The bits of `data_o` not holding the sample take the value selected by `fill_i`: 0 gives zeros, 1 gives ones, 2 repeats the sample MSB, 3 repeats the sample LSB.
- R8: In sizes 5 and 7 the even slot is the left sample and the following odd slot is the right sample. One word is emitted after the odd slot, with the left sample in bits [W-1:0] and the right sample in bits [2W-1:W]. Alignment and fill then treat the pair as a single 2W-bit sample, and `slot_o` gives the even slot number.
- R9: A slot whose `slot_off_i` bit is 1 produces no word. In the packed sizes, a pair produces no word if either of its slots is off.
- R10: With `mono_i`=1 the sample of each odd slot is replaced by the sample of the even slot just before it. In the packed sizes the right half of the word repeats the left half.
- R11: `mode_i`=2 captures one bit on each bit-clock edge, rising and falling. The frame sync is still detected on rising edges only. Values 1 and 3 behave as 0.
- R12: With `loop_i`=1 the bits are taken from `tx_sd_i` and `sd_i` is ignored. With 0 the reverse holds.
- R13: Each emitted word is shown with `valid_o` high for exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Frame sync |
| sd_i | input | 1 | Serial data line |
| tx_sd_i | input | 1 | Local transmit line used in loop-back |
| mode_i | input | 2 | Capture mode, 2 = both edges |
| size_i | input | 3 | Sample size code |
| slot_left_i | input | 1 | Sample taken from the start of the slot |
| word_left_i | input | 1 | Sample placed at the top of the word |
| fill_i | input | 2 | Fill selection for spare word bits |
| lsb_first_i | input | 1 | Wire bit order, 1 = LSB first |
| slot_off_i | input | MAX_SLOTS | Per-slot mute |
| mono_i | input | 1 | Repeat left channel as right channel |
| loop_i | input | 1 | Select the transmit line as data source |
| last_slot_i | input | clog2(MAX_SLOTS) | Number of the last slot in a frame |
| valid_o | output | 1 | One-cycle word strobe |
| data_o | output | 32 | Formatted word |
| slot_o | output | clog2(MAX_SLOTS) | Slot number of the word |

## Verification
A slip in the bit counter moves the slot boundaries. That shows up within one slot as a shifted or rotated value in every following word of the frame, and as a wrong word count at the end of the frame. A stale left-sample holding register is only visible when mono or pair packing is on. It shows up on the next odd slot as a right channel that does not match. A wrong frame-start detector produces words before any sync or words past the last slot, and each frame comparison catches these through its word count.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;
  localparam int WORD_W = 32;
  localparam int WBIT_W = $clog2(WORD_W);
  localparam logic [1:0] MODE_BOTH_EDGES = 2'd2;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_ONE  = 2'd1,
    FILL_MSB  = 2'd2,
    FILL_LSB  = 2'd3
  } fill_e;

  function automatic logic [5:0] sample_width(input logic [2:0] code);
    case (code)
      3'd0:       return 6'd32;
      3'd1:       return 6'd24;
      3'd2:       return 6'd20;
      3'd3:       return 6'd18;
      3'd4, 3'd5: return 6'd16;
      default:    return 6'd8;
    endcase
  endfunction

  function automatic logic is_pair(input logic [2:0] code);
    return (code == 3'd5) || (code == 3'd7);
  endfunction
endpackage

// File: rtl/rxfmt_sync.sv
module rxfmt_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/rxfmt_deser.sv
module rxfmt_deser #(
  parameter int SLOT_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              fsync_i,
  input  logic              sd_i,
  input  logic              both_edges_i,
  input  logic [IDX_W-1:0]  last_slot_i,
  output logic              done_o,
  output logic [SLOT_W-1:0] raw_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int CNT_W = $clog2(SLOT_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SLOT_W - 1);

  logic              sclk_q, fs_q, active_q, done_q;
  logic [CNT_W-1:0]  bit_q;
  logic [IDX_W-1:0]  slot_q, idx_q;
  logic [SLOT_W-1:0] raw_q, raw_next;
  logic              rise, fall, cap, start;

  assign rise     = sclk_i & ~sclk_q;
  assign fall     = ~sclk_i & sclk_q;
  assign cap      = rise | (fall & both_edges_i);
  assign start    = rise & fsync_i & ~fs_q;
  assign raw_next = {raw_q[SLOT_W-2:0], sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      fs_q     <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      slot_q   <= '0;
      idx_q    <= '0;
      raw_q    <= '0;
    end else begin
      sclk_q <= sclk_i;
      done_q <= 1'b0;
      if (rise) fs_q <= fsync_i;
      if (start) begin
        // frame sync restarts the slot sequence, even mid-frame
        raw_q    <= raw_next;
        bit_q    <= CNT_W'(1);
        slot_q   <= '0;
        active_q <= 1'b1;
      end else if (cap && active_q) begin
        raw_q <= raw_next;
        if (bit_q == LAST_BIT) begin
          bit_q  <= '0;
          done_q <= 1'b1;
          idx_q  <= slot_q;
          if (slot_q == last_slot_i) active_q <= 1'b0;
          else                       slot_q   <= slot_q + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign raw_o  = raw_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/rxfmt_extract.sv
module rxfmt_extract
  import rxfmt_pkg::*;
#(
  parameter int SLOT_W = 32
) (
  input  logic [SLOT_W-1:0] raw_i,
  input  logic [5:0]        width_i,
  input  logic              take_left_i,
  input  logic              lsb_first_i,
  output logic [WORD_W-1:0] sample_o
);
  logic [SLOT_W-1:0] aligned;
  logic [WORD_W-1:0] seq, mask;

  always_comb begin
    aligned = take_left_i ? (raw_i >> (SLOT_W - int'(width_i))) : raw_i;
    mask    = (width_i >= 6'(WORD_W)) ? '1
            : ((WORD_W'(1) << width_i) - WORD_W'(1));
    seq     = aligned[WORD_W-1:0] & mask;
    sample_o = seq;
    if (lsb_first_i) begin
      sample_o = '0;
      for (int i = 0; i < WORD_W; i++) begin
        if (i < int'(width_i)) sample_o[i] = seq[WBIT_W'(int'(width_i) - 1 - i)];
      end
    end
  end
endmodule

// File: rtl/rxfmt_place.sv
module rxfmt_place
  import rxfmt_pkg::*;
(
  input  logic [WORD_W-1:0] val_i,
  input  logic [5:0]        width_i,
  input  logic              word_left_i,
  input  fill_e             fill_i,
  output logic [WORD_W-1:0] word_o
);
  logic fill_bit;
  int   w;

  always_comb begin
    w = int'(width_i);
    case (fill_i)
      FILL_ZERO: fill_bit = 1'b0;
      FILL_ONE:  fill_bit = 1'b1;
      FILL_MSB:  fill_bit = val_i[WBIT_W'(w - 1)];
      default:   fill_bit = val_i[0];
    endcase
    for (int i = 0; i < WORD_W; i++) begin
      if (word_left_i) word_o[i] = (i >= WORD_W - w) ? val_i[WBIT_W'(i - WORD_W + w)] : fill_bit;
      else             word_o[i] = (i < w) ? val_i[i] : fill_bit;
    end
  end
endmodule

// File: rtl/rxfmt_top.sv
module rxfmt_top
  import rxfmt_pkg::*;
#(
  parameter int SLOT_W    = 32,
  parameter int MAX_SLOTS = 8,
  localparam int IDX_W    = $clog2(MAX_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 fsync_i,
  input  logic                 sd_i,
  input  logic                 tx_sd_i,
  input  logic [1:0]           mode_i,
  input  logic [2:0]           size_i,
  input  logic                 slot_left_i,
  input  logic                 word_left_i,
  input  logic [1:0]           fill_i,
  input  logic                 lsb_first_i,
  input  logic [MAX_SLOTS-1:0] slot_off_i,
  input  logic                 mono_i,
  input  logic                 loop_i,
  input  logic [IDX_W-1:0]     last_slot_i,
  output logic                 valid_o,
  output logic [WORD_W-1:0]    data_o,
  output logic [IDX_W-1:0]     slot_o
);
  logic [2:0]        sync_d, sync_q;
  logic              done;
  logic [SLOT_W-1:0] raw;
  logic [IDX_W-1:0]  idx, even_idx, slot_sel;
  logic [5:0]        w_one, w_sel;
  logic              pair_mode, odd, emit;
  logic [WORD_W-1:0] cur, hold_q, right_v, pair_v, val_sel, placed;
  logic              valid_q;
  logic [WORD_W-1:0] data_q;
  logic [IDX_W-1:0]  slot_q;

  assign sync_d = {sclk_i, fsync_i, loop_i ? tx_sd_i : sd_i};

  rxfmt_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  rxfmt_deser #(.SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_deser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sync_q[2]),
    .fsync_i     (sync_q[1]),
    .sd_i        (sync_q[0]),
    .both_edges_i(mode_i == MODE_BOTH_EDGES),
    .last_slot_i (last_slot_i),
    .done_o      (done),
    .raw_o       (raw),
    .idx_o       (idx)
  );

  assign w_one     = sample_width(size_i);
  assign pair_mode = is_pair(size_i);

  rxfmt_extract #(.SLOT_W(SLOT_W)) u_extract (
    .raw_i      (raw),
    .width_i    (w_one),
    .take_left_i(slot_left_i),
    .lsb_first_i(lsb_first_i),
    .sample_o   (cur)
  );

  always_comb begin
    odd      = idx[0];
    even_idx = {idx[IDX_W-1:1], 1'b0};
    right_v  = (mono_i && odd) ? hold_q : cur;
    pair_v   = hold_q | (right_v << w_one);
    if (pair_mode) begin
      val_sel  = pair_v;
      w_sel    = w_one << 1;
      slot_sel = even_idx;
      emit     = done && odd && !slot_off_i[idx] && !slot_off_i[even_idx];
    end else begin
      val_sel  = right_v;
      w_sel    = w_one;
      slot_sel = idx;
      emit     = done && !slot_off_i[idx];
    end
  end

  rxfmt_place u_place (
    .val_i      (val_sel),
    .width_i    (w_sel),
    .word_left_i(word_left_i),
    .fill_i     (fill_e'(fill_i)),
    .word_o     (placed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      slot_q  <= '0;
    end else begin
      valid_q <= emit;
      if (done && !odd) hold_q <= cur;
      if (emit) begin
        data_q <= placed;
        slot_q <= slot_sel;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign slot_o  = slot_q;
endmodule

// File: rtl/rxfmt_chk.sv
module rxfmt_chk #(
  parameter int MAX_SLOTS = 8,
  localparam int IDX_W    = $clog2(MAX_SLOTS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           size_i,
  input logic                 word_left_i,
  input logic [1:0]           fill_i,
  input logic [MAX_SLOTS-1:0] slot_off_i,
  input logic [IDX_W-1:0]     last_slot_i,
  input logic                 valid_o,
  input logic [31:0]          data_o,
  input logic [IDX_W-1:0]     slot_o
);
  logic pair_mode;
  assign pair_mode = (size_i == 3'd5) || (size_i == 3'd7);

  a_r13_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r9_muted_slot_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !slot_off_i[slot_o]);

  a_r8_pair_even_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && pair_mode) |-> (!slot_o[0] && !slot_off_i[slot_o | IDX_W'(1)]));

  a_r7_fill_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && size_i == 3'd6 && !word_left_i && fill_i == 2'd1) |-> (data_o[31:8] == 24'hFFFFFF));

  a_r2_slot_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (slot_o <= last_slot_i));
endmodule

bind rxfmt_top rxfmt_chk #(.MAX_SLOTS(MAX_SLOTS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .size_i     (size_i),
  .word_left_i(word_left_i),
  .fill_i     (fill_i),
  .slot_off_i (slot_off_i),
  .last_slot_i(last_slot_i),
  .valid_o    (valid_o),
  .data_o     (data_o),
  .slot_o     (slot_o)
);

// File: tb/test_rxfmt_top.sv
`timescale 1ns/1ps
module test_rxfmt_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk_i = 0, fsync_i = 0, sd_i = 0, tx_sd_i = 0;
  logic [1:0] mode_i = 0, fill_i = 0;
  logic [2:0] size_i = 0, last_slot_i = 0;
  logic slot_left_i = 0, word_left_i = 0, lsb_first_i = 0, mono_i = 0, loop_i = 0;
  logic [7:0] slot_off_i = 0;
  logic valid_o;
  logic [31:0] data_o;
  logic [2:0] slot_o;

  always #2 clk = ~clk;

  rxfmt_top i_rxfmt_top (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk_i), .fsync_i(fsync_i), .sd_i(sd_i),
    .tx_sd_i(tx_sd_i), .mode_i(mode_i), .size_i(size_i), .slot_left_i(slot_left_i),
    .word_left_i(word_left_i), .fill_i(fill_i), .lsb_first_i(lsb_first_i),
    .slot_off_i(slot_off_i), .mono_i(mono_i), .loop_i(loop_i), .last_slot_i(last_slot_i),
    .valid_o(valid_o), .data_o(data_o), .slot_o(slot_o)
  );

  int checks = 0, errs = 0, double_pulse = 0;
  bit finished = 0, prev_valid = 0;
  logic [34:0] got_q[$], exp_q[$];
  logic [31:0] slot_raw [8];

  always @(negedge clk) begin
    if (valid_o) got_q.push_back({slot_o, data_o});
    if (valid_o && prev_valid) double_pulse++;
    prev_valid = valid_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int wid(input logic [2:0] s);
    case (s)
      0: return 32; 1: return 24; 2: return 20; 3: return 18;
      4, 5: return 16;
      default: return 8;
    endcase
  endfunction

  // wire bit k of a slot is raw[31-k]
  function automatic logic [31:0] m_ext(input logic [31:0] raw, input int w, input bit sl, input bit lf);
    logic [31:0] r = 0;
    int st = sl ? 0 : 32 - w;
    for (int j = 0; j < w; j++) begin
      if (lf) r[j] = raw[31 - (st + j)];
      else    r[w - 1 - j] = raw[31 - (st + j)];
    end
    return r;
  endfunction

  function automatic logic [31:0] m_place(input logic [31:0] v, input int w, input bit wl, input logic [1:0] fl);
    logic [31:0] mask, x;
    bit fb;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    case (fl)
      0: fb = 0; 1: fb = 1; 2: fb = v[w - 1]; default: fb = v[0];
    endcase
    x = (v & mask) | (fb ? ~mask : 32'd0);
    if (wl && w < 32) x = (x << (32 - w)) | (x >> w);
    return x;
  endfunction

  task automatic put(input bit b, input bit f);
    sd_i = loop_i ? ~b : b;
    tx_sd_i = loop_i ? b : ~b;
    fsync_i = f;
  endtask

  task automatic bit_normal(input bit b, input bit f);
    put(b, f);
    repeat (2) @(negedge clk); sclk_i = 1;
    repeat (4) @(negedge clk); sclk_i = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bit_pair(input bit b0, input bit b1, input bit f);
    put(b0, f);
    repeat (2) @(negedge clk); sclk_i = 1;
    repeat (2) @(negedge clk); put(b1, f);
    repeat (2) @(negedge clk); sclk_i = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic build_expected();
    int w = wid(size_i);
    bit pair = (size_i == 5) || (size_i == 7);
    logic [31:0] cur, hold = 0, rv;
    exp_q.delete();
    for (int s = 0; s <= int'(last_slot_i); s++) begin
      cur = m_ext(slot_raw[s], w, slot_left_i, lsb_first_i);
      if (s % 2 == 0) begin
        if (!pair && !slot_off_i[s]) exp_q.push_back({3'(s), m_place(cur, w, word_left_i, fill_i)});
        hold = cur;
      end else begin
        rv = mono_i ? hold : cur;
        if (pair) begin
          if (!slot_off_i[s] && !slot_off_i[s - 1])
            exp_q.push_back({3'(s - 1), m_place(hold | (rv << w), 2 * w, word_left_i, fill_i)});
        end else if (!slot_off_i[s]) begin
          exp_q.push_back({3'(s), m_place(rv, w, word_left_i, fill_i)});
        end
      end
    end
  endtask

  task automatic run_frame(input string tag);
    bit both = (mode_i == 2);
    got_q.delete();
    build_expected();
    for (int s = 0; s <= int'(last_slot_i); s++) begin
      for (int k = 0; k < 32; k += (both ? 2 : 1)) begin
        if (both) bit_pair(slot_raw[s][31 - k], slot_raw[s][30 - k], s == 0 && k == 0);
        else      bit_normal(slot_raw[s][31 - k], s == 0 && k == 0);
      end
    end
    // trailing bits without sync must be ignored (R2)
    for (int k = 0; k < 6; k++) bit_normal(1'($urandom), 1'b0);
    repeat (20) @(negedge clk);
    chk(got_q.size() == exp_q.size(), {tag, " R2 word count"}, 64'(got_q.size()), 64'(exp_q.size()));
    if (got_q.size() == exp_q.size())
      foreach (exp_q[i]) chk(got_q[i] === exp_q[i], {tag, " word"}, 64'(got_q[i]), 64'(exp_q[i]));
  endtask

  task automatic base_cfg();
    mode_i = 0; size_i = 0; slot_left_i = 0; word_left_i = 0; fill_i = 0;
    lsb_first_i = 0; slot_off_i = 0; mono_i = 0; loop_i = 0; last_slot_i = 3;
    foreach (slot_raw[i]) slot_raw[i] = $urandom;
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0, "R1 valid in reset", 64'(valid_o), 0);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    chk(data_o === 32'd0, "R1 data after reset", 64'(data_o), 0);
    base_cfg();
    got_q.delete();
    for (int k = 0; k < 40; k++) bit_normal(1'($urandom), 1'b0);
    repeat (10) @(negedge clk);
    chk(got_q.size() == 0, "R1 no words before sync", 64'(got_q.size()), 0);

    base_cfg(); last_slot_i = 7; run_frame("R2");
    base_cfg(); size_i = 3; run_frame("R3");
    base_cfg(); size_i = 1; fill_i = 2; run_frame("R3");
    base_cfg(); size_i = 4; slot_left_i = 1; run_frame("R4");
    base_cfg(); size_i = 2; lsb_first_i = 1; run_frame("R5");
    base_cfg(); size_i = 1; word_left_i = 1; fill_i = 3; run_frame("R6");
    base_cfg(); size_i = 6; fill_i = 1; run_frame("R7");
    base_cfg(); size_i = 6; fill_i = 2; slot_raw[0] = 32'h0000_00F0; run_frame("R7");
    base_cfg(); size_i = 7; fill_i = 2; word_left_i = 1; last_slot_i = 5; run_frame("R8");
    base_cfg(); size_i = 5; last_slot_i = 6; run_frame("R8");
    base_cfg(); last_slot_i = 7; slot_off_i = 8'b1010_0110; run_frame("R9");
    base_cfg(); size_i = 7; last_slot_i = 7; slot_off_i = 8'b0010_0001; run_frame("R9");
    base_cfg(); mono_i = 1; size_i = 4; last_slot_i = 5; run_frame("R10");
    base_cfg(); mono_i = 1; size_i = 7; run_frame("R10");
    base_cfg(); mode_i = 2; last_slot_i = 5; run_frame("R11");
    base_cfg(); mode_i = 3; size_i = 1; run_frame("R11");
    base_cfg(); mode_i = 1; run_frame("R11");
    base_cfg(); loop_i = 1; size_i = 4; run_frame("R12");

    for (int n = 0; n < 14; n++) begin
      base_cfg();
      mode_i = 2'($urandom); size_i = 3'($urandom); slot_left_i = 1'($urandom);
      word_left_i = 1'($urandom); fill_i = 2'($urandom); lsb_first_i = 1'($urandom);
      slot_off_i = 8'($urandom & $urandom & $urandom); mono_i = 1'($urandom);
      loop_i = 1'($urandom); last_slot_i = 3'($urandom);
      run_frame("R2 random");
    end

    chk(double_pulse == 0, "R13 valid wider than one cycle", 64'(double_pulse), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL R2 watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule